// File: doc/BRIEF.md
# Thermal Alert and Trip Signaling

This block turns a digital die-temperature code into the alert signals a platform watches. It drives an active-low "hot" line while the temperature sits above a programmable trip threshold. It raises a single-cycle interrupt on the edges of that line, each edge kind with its own enable, and keeps a sticky status bit that software clears by writing a one. A separate active-low trip line fires at a fixed critical temperature and stays latched until reset. Platform logic uses the trip line to cut the core supply.

While the part is in a low-power state with its clocks stopped, a new hot condition is not signalled. If the hot line was already asserted when the low-power state began, it stays asserted through that state. It is released only once the low-power state has ended and the temperature is at or below the threshold. Every output is a flop, so each one reacts on the clock edge that samples the inputs. It therefore changes one cycle after an input change.

Top module: `thermal_alert`

## Requirements
- R1: While reset is held and on the first cycle after it, hot_n = 1, trip_n = 1, irq_pulse = 0 and irq_sts = 0.
- R2: Outside low power, hot_n goes to 0 one cycle after temp_code becomes strictly greater than trip_thresh; a code equal to the threshold does not assert it.
- R3: Outside low power, hot_n returns to 1 one cycle after temp_code becomes less than or equal to trip_thresh.
- R4: While lowpwr = 1 and hot_n = 1, hot_n stays 1 whatever the temperature; after lowpwr returns to 0, a temperature still above the threshold asserts hot_n one cycle later.
- R5: If hot_n = 0 while lowpwr = 1, hot_n stays 0 for the whole low-power interval even if the temperature falls; it returns to 1 only one cycle after lowpwr = 0 with temp_code <= trip_thresh.
- R6: When hot_n goes 1 to 0 and irq_en_rise = 1 in the sampling cycle, irq_pulse is 1 for exactly the cycle in which hot_n first reads 0; with irq_en_rise = 0 no pulse occurs.
- R7: When hot_n goes 0 to 1 and irq_en_fall = 1, irq_pulse is 1 in the cycle hot_n first reads 1; with irq_en_fall = 0 no pulse occurs.
- R8: irq_sts becomes 1 in the same cycle as any irq_pulse and holds. It clears one cycle after sts_wr = 1 with sts_wdata = 1. sts_wr with sts_wdata = 0 has no effect. A pulse in the same cycle as a clear leaves it at 1.
- R9: trip_n goes to 0 one cycle after temp_code >= CRIT_CODE (default 125, one code per degree Celsius) and stays 0 until reset, even when the temperature falls.
- R10: The trip detection ignores trip_thresh and lowpwr: it fires with the threshold above the critical code and while in low power.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TW | Current temperature code |
| trip_thresh | input | TW | Hot threshold code |
| lowpwr | input | 1 | 1 while the part is in a clocks-stopped low-power state |
| irq_en_rise | input | 1 | Enables the interrupt on assertion of hot_n |
| irq_en_fall | input | 1 | Enables the interrupt on deassertion of hot_n |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data; 1 clears irq_sts |
| hot_n | output | 1 | Active-low hot indication |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_sts | output | 1 | Sticky interrupt status |
| trip_n | output | 1 | Active-low latched critical trip |

## Verification
The hot register is both the output and the memory that carries a low-power hold. A wrong value in it shows up on hot_n in the next cycle. It also shows up at once as a spurious or missing irq_pulse, because the pulse is derived from its change. A trip latch that drops or never sets shows on trip_n one cycle after the critical code. A status bit that loses its set-over-clear priority is visible the cycle after the colliding write. The stimulus walks the equal-to-threshold boundary, both low-power orderings, both edge enables and the critical boundary at 124 and 125.

// File: rtl/thermal_alert.sv
module thermal_alert #(
  parameter int TW = 8,
  parameter logic [TW-1:0] CRIT_CODE = TW'(125)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_code,
  input  logic [TW-1:0] trip_thresh,
  input  logic          lowpwr,
  input  logic          irq_en_rise,
  input  logic          irq_en_fall,
  input  logic          sts_wr,
  input  logic          sts_wdata,
  output logic          hot_n,
  output logic          irq_pulse,
  output logic          irq_sts,
  output logic          trip_n
);

  logic hot_q, irq_q, sts_q, trip_q;
  logic above, hot_d, rise, fall, irq_d, clr, crit;

  assign above = temp_code > trip_thresh;
  assign crit  = temp_code >= CRIT_CODE;
  // low power freezes the hot state: no new assertion, no release
  assign hot_d = lowpwr ? hot_q : above;
  assign rise  = hot_d & ~hot_q;
  assign fall  = ~hot_d & hot_q;
  assign irq_d = (rise & irq_en_rise) | (fall & irq_en_fall);
  assign clr   = sts_wr & sts_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q  <= 1'b0;
      irq_q  <= 1'b0;
      sts_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      hot_q  <= hot_d;
      irq_q  <= irq_d;
      sts_q  <= irq_d | (sts_q & ~clr);
      trip_q <= trip_q | crit;
    end
  end

  assign hot_n     = ~hot_q;
  assign irq_pulse = irq_q;
  assign irq_sts   = sts_q;
  assign trip_n    = ~trip_q;

endmodule

// File: rtl/thermal_alert_chk.sv
module thermal_alert_chk #(
  parameter int TW = 8,
  parameter logic [TW-1:0] CRIT_CODE = TW'(125)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] temp_code,
  input logic [TW-1:0] trip_thresh,
  input logic          lowpwr,
  input logic          hot_n,
  input logic          irq_pulse,
  input logic          irq_sts,
  input logic          trip_n
);

  p_hot_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowpwr && temp_code > trip_thresh) |=> !hot_n);

  p_hot_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowpwr && temp_code <= trip_thresh) |=> hot_n);

  p_lp_no_assert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr && hot_n) |=> hot_n);

  p_lp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr && !hot_n) |=> !hot_n);

  p_irq_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (hot_n != $past(hot_n)));

  p_sts_follows_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_sts);

  p_trip_fires_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= CRIT_CODE) |=> !trip_n);

  p_trip_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |=> !trip_n);

endmodule

bind thermal_alert thermal_alert_chk #(.TW(TW), .CRIT_CODE(CRIT_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .trip_thresh(trip_thresh),
  .lowpwr(lowpwr), .hot_n(hot_n), .irq_pulse(irq_pulse), .irq_sts(irq_sts),
  .trip_n(trip_n)
);

// File: tb/sim_thermal_alert.sv
module sim_thermal_alert;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] temp_code = 8'd25, trip_thresh = 8'd80;
  logic lowpwr = 1'b0, irq_en_rise = 1'b0, irq_en_fall = 1'b0;
  logic sts_wr = 1'b0, sts_wdata = 1'b0;
  logic hot_n, irq_pulse, irq_sts, trip_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic hot_n; logic irq; logic sts; logic trip_n; string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  thermal_alert u0 (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .trip_thresh(trip_thresh),
    .lowpwr(lowpwr), .irq_en_rise(irq_en_rise), .irq_en_fall(irq_en_fall),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .hot_n(hot_n), .irq_pulse(irq_pulse),
    .irq_sts(irq_sts), .trip_n(trip_n)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (hot_n !== e.hot_n || irq_pulse !== e.irq || irq_sts !== e.sts || trip_n !== e.trip_n) begin
      errors++;
      $display("FAIL %s: got hot_n=%b irq=%b sts=%b trip_n=%b, expected hot_n=%b irq=%b sts=%b trip_n=%b",
               e.tag, hot_n, irq_pulse, irq_sts, trip_n, e.hot_n, e.irq, e.sts, e.trip_n);
    end
  endtask

  // driver: apply inputs at negedge, push the expectation once the edge has sampled them
  task automatic step(input logic [7:0] t, input logic [7:0] th, input logic lp,
                      input logic er, input logic ef, input logic wr, input logic wd,
                      input logic x_hot_n, input logic x_irq, input logic x_sts,
                      input logic x_trip_n, input string tag);
    exp_t e;
    @(negedge clk);
    temp_code = t; trip_thresh = th; lowpwr = lp;
    irq_en_rise = er; irq_en_fall = ef; sts_wr = wr; sts_wdata = wd;
    @(posedge clk);
    e.hot_n = x_hot_n; e.irq = x_irq; e.sts = x_sts; e.trip_n = x_trip_n; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic check_reset(input string tag);
    exp_t e;
    e.hot_n = 1'b1; e.irq = 1'b0; e.sts = 1'b0; e.trip_n = 1'b1; e.tag = tag;
    compare(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset("R1 after reset");

    step(8'd25, 8'd80, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R3 idle cool");
    step(8'd80, 8'd80, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R2 equal not hot");
    step(8'd81, 8'd80, 0, 1, 1, 0, 0, 0, 1, 1, 1, "R2 R6 assert with pulse");
    step(8'd81, 8'd80, 0, 1, 1, 0, 0, 0, 0, 1, 1, "R6 single cycle");
    step(8'd81, 8'd80, 0, 0, 0, 1, 0, 0, 0, 1, 1, "R8 write 0 ignored");
    step(8'd81, 8'd80, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R8 write 1 clears");
    step(8'd70, 8'd80, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R3 R7 release no pulse");
    step(8'd90, 8'd80, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R6 rise disabled");
    step(8'd60, 8'd80, 0, 0, 1, 0, 0, 1, 1, 1, 1, "R7 fall pulse");
    step(8'd60, 8'd80, 0, 0, 0, 1, 1, 1, 0, 0, 1, "R8 clear");
    step(8'd100, 8'd80, 1, 1, 0, 0, 0, 1, 0, 0, 1, "R4 lp suppress");
    step(8'd100, 8'd80, 1, 1, 0, 0, 0, 1, 0, 0, 1, "R4 lp suppress hold");
    step(8'd100, 8'd80, 0, 1, 0, 0, 0, 0, 1, 1, 1, "R4 assert after exit");
    step(8'd50, 8'd80, 1, 1, 1, 0, 0, 0, 0, 1, 1, "R5 held in lp");
    step(8'd50, 8'd80, 1, 1, 1, 0, 0, 0, 0, 1, 1, "R5 still held");
    step(8'd95, 8'd80, 0, 1, 1, 0, 0, 0, 0, 1, 1, "R5 exit while hot");
    step(8'd50, 8'd80, 0, 1, 1, 1, 1, 1, 1, 1, 1, "R5 R8 release, set beats clear");
    step(8'd50, 8'd80, 0, 0, 0, 1, 1, 1, 0, 0, 1, "R8 clear after collision");
    step(8'd50, 8'd40, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 threshold lowered");
    step(8'd50, 8'd60, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R3 threshold raised");
    step(8'd124, 8'd200, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R9 below critical");
    step(8'd125, 8'd200, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 R10 critical trip");
    step(8'd30, 8'd80, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 trip latched");
    @(negedge clk);
    @(negedge clk);

    rst_n = 1'b0;
    temp_code = 8'd25; trip_thresh = 8'd80;
    #1;
    check_reset("R1 reset clears trip");
    @(negedge clk);
    rst_n = 1'b1;
    step(8'd130, 8'd200, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R10 trip in low power");
    step(8'd20, 8'd200, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 trip stays");
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got not done, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule